// File: doc/BRIEF.md
# Type B Reader-to-Card Frame Receiver

This block sits on the card side of a 13.56 MHz proximity link. It takes the demodulated reader-to-card bit stream and turns it into a buffer of received bytes. The input is one line sample per `smp_valid` strobe, with four samples per elementary time unit (etu). Each sample period is a quarter etu. The line level is sampled once per etu, on the third sample of that etu.

The receiver waits for a long low start-of-frame (SOF). The SOF is accepted only if its low phase has the right length in etus. After that, the receiver deframes ten-bit characters. Each character has a start bit at 0, eight data bits sent least significant bit first, and a stop bit at 1. Each good character is written into a buffer that can be read through a registered read port, and `byte_count` follows the number of stored bytes. The frame ends on a character of ten zero bits, which raises `frame_done` for one cycle.

Any timing or framing violation drops the receiver back to idle and discards the frame. `clr` does the same thing on request between frames. CRC checking and command decoding belong to the logic that reads the buffer.

Top module: `typeb_frame_rx`

## Requirements
- R1: After `rst`, or one cycle after `clr` is high, `busy` and `frame_done` are 0 and `byte_count` is 0. A later valid frame is then received normally.
- R2: A low phase of 10, 11 or 12 etus, counted at the mid-etu sample (phase 2 of 0..3, where the first low sample is phase 0), followed by a high mid-etu sample, is a valid SOF. `busy` goes to 1 and `byte_count` goes to 0.
- R3: An SOF whose low phase has 9 or fewer low mid-etu samples before the first high one is rejected, and `busy` stays 0.
- R4: A 13th consecutive low mid-etu sample during SOF checking aborts it, and `busy` stays 0.
- R5: Character bits are taken at each mid-etu sample. Bit 0 is the start bit, bits 1 to 8 are data LSB first, and bit 9 is the stop bit. A character with stop 1 and start 0 stores its data byte at buffer index `byte_count`, then increments `byte_count`. `rd_data` shows the byte at `rd_addr` one clock after the address is applied.
- R6: A character that is not all zero but has stop 0 or start 1 aborts the frame. `busy` goes to 0, `byte_count` goes to 0, and there is no `frame_done`.
- R7: After the SOF or a character, while waiting for a start bit, the 26th consecutive high sample aborts the frame (`busy` 0, `byte_count` 0). Twenty-five high samples do not abort it.
- R8: An all-zero character with at least one byte stored ends the frame. `frame_done` is 1 for exactly one cycle, `busy` falls in that same cycle, and `byte_count` keeps the number of bytes.
- R9: An all-zero character with no byte stored returns to idle without `frame_done`.
- R10: A good character that would bring `byte_count` to `BUF_DEPTH` aborts the frame (`busy` 0, `byte_count` 0, no `frame_done`). At most `BUF_DEPTH`-1 bytes fit in a frame.
- R11: A cycle with `smp_valid` low has no effect: `busy`, `byte_count`, `frame_done` and the receive state all stay as they were, whatever the level of `smp_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous return to idle with zero byte count |
| smp_valid | input | 1 | Marks a cycle that carries a line sample |
| smp_bit | input | 1 | Line sample level |
| rd_addr | input | $clog2(BUF_DEPTH) | Buffer read index |
| rd_data | output | 8 | Byte at `rd_addr`, registered |
| busy | output | 1 | High from a valid SOF until end of frame or abort |
| frame_done | output | 1 | One-cycle pulse on a completed frame |
| byte_count | output | $clog2(BUF_DEPTH+1) | Bytes stored in the current or last frame |

## Verification
The bench builds the receiver with `BUF_DEPTH` set to 4 and keeps the default timing limits. With a depth of 4, the overflow abort happens on the fourth character of a frame, so it can be tested next to a full three-byte frame that completes normally. The default SOF and gap limits are small enough that the bench can probe each edge of the SOF length window and the 25/26-sample gap boundary exactly. Some frames are sent with an invalid cycle carrying an inverted level between every pair of samples, to show that only strobed samples count.

// File: rtl/typeb_rx_pkg.sv
package typeb_rx_pkg;

  localparam int CHAR_BITS = 10;
  localparam int DATA_BITS = CHAR_BITS - 2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_SOF  = 2'd1,
    RX_GAP  = 2'd2,
    RX_CHAR = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    CH_GOOD = 2'd0,
    CH_EOF  = 2'd1,
    CH_BAD  = 2'd2
  } ch_kind_e;

endpackage

// File: rtl/typeb_rx_classify.sv
module typeb_rx_classify
  import typeb_rx_pkg::*;
(
  input  logic [CHAR_BITS-1:0] char_bits,
  output ch_kind_e             kind,
  output logic [DATA_BITS-1:0] data
);

  // Start bit sits in bit 0, stop bit in the top bit.
  always_comb begin
    data = char_bits[CHAR_BITS-2:1];
    if (char_bits == '0) begin
      kind = CH_EOF;
    end else if (char_bits[CHAR_BITS-1] && !char_bits[0]) begin
      kind = CH_GOOD;
    end else begin
      kind = CH_BAD;
    end
  end

endmodule

// File: rtl/typeb_rx_buf.sv
module typeb_rx_buf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port shape: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/typeb_rx_ctrl.sv
module typeb_rx_ctrl
  import typeb_rx_pkg::*;
#(
  parameter int SPE       = 4,
  parameter int MID_PHASE = 2,
  parameter int SOF_MIN   = 10,
  parameter int SOF_MAX   = 12,
  parameter int GAP_MAX   = 25,
  parameter int BUF_DEPTH = 256,
  localparam int PW = $clog2(SPE),
  localparam int LW = $clog2(SOF_MAX + 1),
  localparam int GW = $clog2(GAP_MAX + 1),
  localparam int BW = $clog2(CHAR_BITS),
  localparam int CW = $clog2(BUF_DEPTH + 1),
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 smp_valid,
  input  logic                 smp_bit,
  input  ch_kind_e             kind,
  output logic [CHAR_BITS-1:0] char_next,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic                 busy,
  output logic                 done,
  output logic [CW-1:0]        count
);

  rx_state_e            state, nxt_state;
  logic [PW-1:0]        phase, nxt_phase, phase_inc;
  logic [LW-1:0]        low_cnt, nxt_low;
  logic [GW-1:0]        gap_cnt, nxt_gap;
  logic [BW-1:0]        bit_cnt, nxt_bits;
  logic [CHAR_BITS-2:0] shreg, nxt_sh;
  logic [CW-1:0]        nxt_cnt;
  logic                 nxt_done;
  logic                 at_mid;

  // New bit enters at the top, older bits move toward bit 0.
  assign char_next = {smp_bit, shreg};
  assign wr_addr   = count[AW-1:0];
  assign at_mid    = (phase == PW'(MID_PHASE));
  assign phase_inc = (phase == PW'(SPE - 1)) ? '0 : phase + 1'b1;

  always_comb begin
    nxt_state = state;
    nxt_phase = phase;
    nxt_low   = low_cnt;
    nxt_gap   = gap_cnt;
    nxt_bits  = bit_cnt;
    nxt_sh    = shreg;
    nxt_cnt   = count;
    nxt_done  = 1'b0;
    wr_en     = 1'b0;
    if (smp_valid) begin
      unique case (state)
        RX_IDLE: begin
          if (!smp_bit) begin
            nxt_state = RX_SOF;
            nxt_phase = PW'(1);
            nxt_low   = '0;
          end
        end
        RX_SOF: begin
          nxt_phase = phase_inc;
          if (at_mid) begin
            if (smp_bit) begin
              if (low_cnt >= LW'(SOF_MIN)) begin
                nxt_state = RX_GAP;
                nxt_gap   = '0;
                nxt_cnt   = '0;
              end else begin
                nxt_state = RX_IDLE;
              end
            end else if (low_cnt == LW'(SOF_MAX)) begin
              nxt_state = RX_IDLE;
            end else begin
              nxt_low = low_cnt + 1'b1;
            end
          end
        end
        RX_GAP: begin
          if (smp_bit) begin
            if (gap_cnt == GW'(GAP_MAX)) begin
              nxt_state = RX_IDLE;
              nxt_cnt   = '0;
            end else begin
              nxt_gap = gap_cnt + 1'b1;
            end
          end else begin
            nxt_state = RX_CHAR;
            nxt_phase = PW'(1);
            nxt_bits  = '0;
          end
        end
        RX_CHAR: begin
          nxt_phase = phase_inc;
          if (at_mid) begin
            nxt_sh = char_next[CHAR_BITS-1:1];
            if (bit_cnt == BW'(CHAR_BITS - 1)) begin
              unique case (kind)
                CH_GOOD: begin
                  wr_en = 1'b1;
                  if (count == CW'(BUF_DEPTH - 1)) begin
                    nxt_state = RX_IDLE;
                    nxt_cnt   = '0;
                  end else begin
                    nxt_state = RX_GAP;
                    nxt_gap   = '0;
                    nxt_cnt   = count + 1'b1;
                  end
                end
                CH_EOF: begin
                  nxt_state = RX_IDLE;
                  nxt_done  = (count != '0);
                end
                default: begin
                  nxt_state = RX_IDLE;
                  nxt_cnt   = '0;
                end
              endcase
            end else begin
              nxt_bits = bit_cnt + 1'b1;
            end
          end
        end
        default: nxt_state = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state   <= RX_IDLE;
      phase   <= '0;
      low_cnt <= '0;
      gap_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      count   <= '0;
      done    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state   <= nxt_state;
      phase   <= nxt_phase;
      low_cnt <= nxt_low;
      gap_cnt <= nxt_gap;
      bit_cnt <= nxt_bits;
      shreg   <= nxt_sh;
      count   <= nxt_cnt;
      done    <= nxt_done;
      busy    <= (nxt_state == RX_GAP) || (nxt_state == RX_CHAR);
    end
  end

endmodule

// File: rtl/typeb_frame_rx.sv
module typeb_frame_rx
  import typeb_rx_pkg::*;
#(
  parameter int SPE       = 4,
  parameter int MID_PHASE = 2,
  parameter int SOF_MIN   = 10,
  parameter int SOF_MAX   = 12,
  parameter int GAP_MAX   = 25,
  parameter int BUF_DEPTH = 256
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           smp_valid,
  input  logic                           smp_bit,
  input  logic [$clog2(BUF_DEPTH)-1:0]   rd_addr,
  output logic [DATA_BITS-1:0]           rd_data,
  output logic                           busy,
  output logic                           frame_done,
  output logic [$clog2(BUF_DEPTH+1)-1:0] byte_count
);

  localparam int AW = $clog2(BUF_DEPTH);

  ch_kind_e             kind;
  logic [CHAR_BITS-1:0] char_next;
  logic [DATA_BITS-1:0] char_data;
  logic                 wr_en;
  logic [AW-1:0]        wr_addr;

  typeb_rx_ctrl #(
    .SPE      (SPE),
    .MID_PHASE(MID_PHASE),
    .SOF_MIN  (SOF_MIN),
    .SOF_MAX  (SOF_MAX),
    .GAP_MAX  (GAP_MAX),
    .BUF_DEPTH(BUF_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .smp_valid(smp_valid),
    .smp_bit  (smp_bit),
    .kind     (kind),
    .char_next(char_next),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .busy     (busy),
    .done     (frame_done),
    .count    (byte_count)
  );

  typeb_rx_classify u_cls (
    .char_bits(char_next),
    .kind     (kind),
    .data     (char_data)
  );

  typeb_rx_buf #(
    .DEPTH(BUF_DEPTH),
    .WIDTH(DATA_BITS)
  ) u_buf (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(char_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/typeb_frame_rx_sva.sv
module typeb_frame_rx_sva #(
  parameter int BUF_DEPTH = 256,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          smp_valid,
  input logic          busy,
  input logic          frame_done,
  input logic [CW-1:0] byte_count
);

  // R1
  a_r1_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!busy && !frame_done && byte_count == '0));

  // R8
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(busy) && !busy);

  // R8
  a_r8_done_has_bytes: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> byte_count != '0);

  // R8
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R10
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    byte_count < CW'(BUF_DEPTH));

  // R5
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (byte_count != $past(byte_count)) |->
      (byte_count == $past(byte_count) + 1'b1 || byte_count == '0));

  // R11
  a_r11_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !clr) |=> ($stable(busy) && $stable(byte_count) && !frame_done));

endmodule

bind typeb_frame_rx typeb_frame_rx_sva #(.BUF_DEPTH(BUF_DEPTH)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .smp_valid (smp_valid),
  .busy      (busy),
  .frame_done(frame_done),
  .byte_count(byte_count)
);

// File: tb/typeb_frame_rx_test.sv
module typeb_frame_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int SPE        = 4;
  localparam int AW         = $clog2(DEPTH);
  localparam int CW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          sv  = 1'b0;
  logic          sb  = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy;
  logic          frame_done;
  logic [CW-1:0] byte_count;

  always #(CLK_PERIOD / 2) clk = ~clk;

  typeb_frame_rx #(.BUF_DEPTH(DEPTH)) uut (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .smp_valid (sv),
    .smp_bit   (sb),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (busy),
    .frame_done(frame_done),
    .byte_count(byte_count)
  );

  int         tests = 0;
  int         fails = 0;
  int         pulses = 0;
  int         exp_pulses = 0;
  int         sent_frames = 0;
  int         checked_frames = 0;
  bit         slow = 1'b0;
  bit         finished = 1'b0;
  int         exp_len_q[$];
  logic [7:0] exp_byte_q[$];

  task automatic check(input string req, input longint act, input longint exp,
                       input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse counter, sampled away from the edge.
  always @(posedge clk) begin
    #1;
    if (frame_done) pulses++;
  end

  // Monitor: pops expected frames and compares them with the buffer.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (frame_done) begin
        int n;
        if (exp_len_q.size() == 0) begin
          check("R8", 1, 0, "frame_done with no frame expected");
        end else begin
          n = exp_len_q.pop_front();
          check("R8", byte_count, n, "byte_count at frame end");
          for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_addr = AW'(i);
            @(negedge clk);
            check("R5", rd_data, exp_byte_q.pop_front(), "stored byte");
          end
        end
        checked_frames++;
      end
    end
  end

  // Driver tasks, all entered at a falling edge.
  task automatic put(input logic b);
    sv = 1'b1;
    sb = b;
    @(negedge clk);
    if (slow) begin
      sv = 1'b0;
      sb = ~b;
      @(negedge clk);
    end
    sv = 1'b0;
  endtask

  task automatic etu(input logic b);
    repeat (SPE) put(b);
  endtask

  task automatic idle(input int n);
    repeat (n) put(1'b1);
  endtask

  task automatic send_sof(input int n_low);
    repeat (n_low) etu(1'b0);
    etu(1'b1);
  endtask

  task automatic send_raw(input logic [9:0] v);
    for (int i = 0; i < 10; i++) etu(v[i]);
  endtask

  task automatic send_char(input logic [7:0] d);
    send_raw({1'b1, d, 1'b0});
  endtask

  task automatic expect_byte(input logic [7:0] d);
    exp_byte_q.push_back(d);
  endtask

  task automatic close_frame(input int n);
    exp_len_q.push_back(n);
    sent_frames++;
    exp_pulses++;
    send_raw(10'h000);
    check("R8", busy, 0, "busy after end of frame");
    check("R8", byte_count, n, "byte_count held after end of frame");
    idle(8);
    wait (checked_frames == sent_frames);
    @(negedge clk);
    check("R8", pulses, exp_pulses, "frame_done pulse count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", busy, 0, "busy after reset");
    check("R1", frame_done, 0, "frame_done after reset");
    check("R1", byte_count, 0, "byte_count after reset");
    idle(6);

    // Three-byte frame, shortest valid SOF.
    send_sof(10);
    check("R2", busy, 1, "busy after 10-etu SOF");
    check("R2", byte_count, 0, "byte_count after SOF");
    send_char(8'hA5); expect_byte(8'hA5);
    check("R5", byte_count, 1, "count after first char");
    send_char(8'h3C); expect_byte(8'h3C);
    send_char(8'h01); expect_byte(8'h01);
    check("R5", byte_count, 3, "count after third char");
    close_frame(3);

    // Longest valid SOF, samples interleaved with ignored cycles.
    slow = 1'b1;
    send_sof(12);
    check("R2", busy, 1, "busy after 12-etu SOF");
    send_char(8'h7E); expect_byte(8'h7E);
    check("R11", byte_count, 1, "count with invalid cycles interleaved");
    close_frame(1);
    slow = 1'b0;

    // SOF too short.
    send_sof(9);
    check("R3", busy, 0, "busy after 9-etu SOF");
    idle(8);
    check("R3", busy, 0, "busy stays low after short SOF");

    // SOF too long.
    send_sof(13);
    check("R4", busy, 0, "busy after 13-etu SOF");
    idle(8);
    check("R4", busy, 0, "busy stays low after long SOF");

    // Gap limit: 25 high samples allowed, 26th aborts.
    send_sof(10);
    idle(24);
    check("R7", busy, 1, "busy after 25 high samples");
    idle(1);
    check("R7", busy, 0, "busy after 26 high samples");
    check("R7", byte_count, 0, "count after gap abort");

    // Bad stop bit.
    idle(4);
    send_sof(10);
    send_char(8'h42);
    check("R6", byte_count, 1, "count before bad char");
    send_raw({1'b0, 8'h55, 1'b0});
    check("R6", busy, 0, "busy after bad stop bit");
    check("R6", byte_count, 0, "count after bad stop bit");
    idle(8);
    check("R6", pulses, exp_pulses, "no frame_done on bad char");

    // End of frame with no byte.
    send_sof(10);
    send_raw(10'h000);
    check("R9", busy, 0, "busy after empty frame");
    check("R9", byte_count, 0, "count after empty frame");
    idle(8);
    check("R9", pulses, exp_pulses, "no frame_done on empty frame");

    // Overflow: fourth byte reaches the depth of 4.
    send_sof(10);
    send_char(8'h11);
    send_char(8'h22);
    send_char(8'h33);
    check("R10", byte_count, 3, "count at depth minus one");
    check("R10", busy, 1, "busy at depth minus one");
    send_char(8'h44);
    check("R10", busy, 0, "busy after overflow");
    check("R10", byte_count, 0, "count after overflow");
    idle(8);
    check("R10", pulses, exp_pulses, "no frame_done on overflow");

    // Long stretch of invalid cycles between characters.
    send_sof(10);
    send_char(8'h5A); expect_byte(8'h5A);
    for (int i = 0; i < 40; i++) begin
      sv = 1'b0;
      sb = i[0];
      @(negedge clk);
    end
    check("R11", busy, 1, "busy held across invalid cycles");
    check("R11", byte_count, 1, "count held across invalid cycles");
    send_char(8'hC3); expect_byte(8'hC3);
    close_frame(2);

    // Clear in mid frame, then a normal frame.
    send_sof(10);
    send_char(8'h99);
    check("R1", byte_count, 1, "count before clear");
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R1", busy, 0, "busy after clear");
    check("R1", byte_count, 0, "count after clear");
    idle(8);
    send_sof(11);
    send_char(8'h0F); expect_byte(8'h0F);
    close_frame(1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog (R8 flow): actual still running, expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule